// File: doc/BRIEF.md
# Line Loss-of-Signal and Driver Activity Monitor

This block watches the two directions of a bipolar line interface for dead lines. On the receive side it takes one mark/space decision per recovered bit, given as a positive rail, a negative rail and a bit strobe. After a long unbroken run of spaces it raises a loss-of-signal alarm. While that alarm is up it also asks for the recovered clock output to be replaced by the master clock. The alarm is deliberately sticky. It drops only once the received ones density is back: enough marks in a sliding window of recent bits, and no over-long trailing gap.

On the transmit side the same kind of decision, taken from a monitor tap on the line driver output, feeds a shorter run detector. It flags a silent driver and releases on the first mark it sees, or when the control logic issues a synchronous clear. Each alarm also produces a one-cycle change pulse, which a separate interrupt block can latch. Pulse slicing and the glitch-free clock multiplexer sit outside this block. Here the clock request is only a registered select level.

Top module: `line_alarm_monitor`

## Requirements
- R1: A synchronous reset clears both alarms, both change pulses, the clock-select request and both space-run counters. After reset, a loss alarm needs a full fresh run of 175 spaces.
- R2: `los_alarm` goes high one clock after the receive strobe that carries the 175th consecutive space. A run of 174 spaces does not raise it, and any receive mark restarts the count.
- R3: While `los_alarm` is high, it goes low one clock after a receive strobe on which two things hold. The last 32 received bits, including this one, hold at least 4 marks. The trailing run of spaces is no longer than 15. Marks spaced so that a 32-bit window never holds 4 of them leave the alarm high.
- R4: `clk_sel_master` equals `los_alarm` on every cycle. A 1 selects the master clock.
- R5: `los_change` is high for exactly the one cycle in which `los_alarm` has just changed value, and low otherwise.
- R6: `drv_alarm` goes high one clock after the transmit-monitor strobe that carries the 63rd consecutive space. 62 spaces do not raise it.
- R7: A single monitored mark clears `drv_alarm` one clock after its strobe and restarts the transmit run count.
- R8: `drv_clr` high for one cycle clears `drv_alarm` and the transmit run count on the next edge. It wins over a transmit strobe in the same cycle.
- R9: `drv_change` is high for exactly the one cycle in which `drv_alarm` has just changed value.
- R10: Rail inputs are ignored on cycles where their strobe is low. They change neither the alarm nor the run count.
- R11: A mark is a strobe with either rail high (positive or negative pulse). A space is a strobe with both rails low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_en | input | 1 | Receive bit strobe, one per recovered bit |
| rx_pos | input | 1 | Receive positive-pulse decision |
| rx_neg | input | 1 | Receive negative-pulse decision |
| tx_bit_en | input | 1 | Transmit-monitor bit strobe |
| tx_pos | input | 1 | Monitored positive-pulse decision |
| tx_neg | input | 1 | Monitored negative-pulse decision |
| drv_clr | input | 1 | Synchronous clear of the driver alarm |
| los_alarm | output | 1 | Receive loss-of-signal alarm |
| los_change | output | 1 | One-cycle pulse on any loss-alarm change |
| clk_sel_master | output | 1 | Request to output the master clock instead of the recovered clock |
| drv_alarm | output | 1 | Silent-driver alarm |
| drv_change | output | 1 | One-cycle pulse on any driver-alarm change |

## Verification
The properties assume that every input is a clean, known level sampled at the rising edge. They also assume the strobes stay low while reset is held, so that the first post-reset cycle starts from idle. The bench meets both assumptions by changing every input on the falling edge, keeping strobes low around reset and clear pulses, and alternating which single rail carries a mark. It drives the transmit clear only on cycles with no strobe, except in the deliberate same-cycle priority case.

// File: rtl/lam_pkg.sv
package lam_pkg;

  // Bits needed to hold a count from 0 up to and including max_val.
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/lam_run_counter.sv
// Saturating count of consecutive spaces, advanced once per strobe.
module lam_run_counter #(
  parameter int LIMIT = 175,
  parameter int W     = lam_pkg::cnt_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         space,
  output logic [W-1:0] run_len,
  output logic [W-1:0] run_after
);

  localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

  always_comb begin
    if (!step)                run_after = run_len;
    else if (!space)          run_after = '0;
    else if (run_len >= LIMIT_V) run_after = LIMIT_V;
    else                      run_after = run_len + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) run_len <= '0;
    else            run_len <= run_after;
  end

endmodule

// File: rtl/lam_density_window.sv
// Sliding record of the last WIN_LEN bit decisions with a mark count.
module lam_density_window #(
  parameter int WIN_LEN = 32,
  parameter int PW      = lam_pkg::cnt_width(WIN_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          mark,
  output logic [PW-1:0] pop_after
);

  logic [WIN_LEN-1:0] win_q;
  logic [WIN_LEN-1:0] win_after;

  always_comb begin
    if (step) win_after = {win_q[WIN_LEN-2:0], mark};
    else      win_after = win_q;
  end

  always_comb begin
    pop_after = '0;
    for (int i = 0; i < WIN_LEN; i++) begin
      pop_after = pop_after + PW'(win_after[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= win_after;
  end

endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor #(
  parameter int LOS_RUN   = 175,
  parameter int WIN_LEN   = 32,
  parameter int MIN_MARKS = 4,
  parameter int MAX_GAP   = 15,
  parameter int DRV_RUN   = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit_en,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic tx_bit_en,
  input  logic tx_pos,
  input  logic tx_neg,
  input  logic drv_clr,
  output logic los_alarm,
  output logic los_change,
  output logic clk_sel_master,
  output logic drv_alarm,
  output logic drv_change
);

  localparam int RW = lam_pkg::cnt_width(LOS_RUN);
  localparam int TW = lam_pkg::cnt_width(DRV_RUN);
  localparam int PW = lam_pkg::cnt_width(WIN_LEN);
  localparam logic [RW-1:0] LOS_RUN_V  = RW'(LOS_RUN);
  localparam logic [RW-1:0] MAX_GAP_V  = RW'(MAX_GAP);
  localparam logic [TW-1:0] DRV_RUN_V  = TW'(DRV_RUN);
  localparam logic [PW-1:0] MIN_MARK_V = PW'(MIN_MARKS);

  logic rx_mark, tx_mark;
  assign rx_mark = rx_pos | rx_neg;
  assign tx_mark = tx_pos | tx_neg;

  // ---------------- receive side ----------------
  logic [RW-1:0] rx_run, rx_run_after;
  logic [PW-1:0] rx_pop_after;

  lam_run_counter #(.LIMIT(LOS_RUN), .W(RW)) u_rx_run (
    .clk       (clk),
    .rst       (rst),
    .clr       (1'b0),
    .step      (rx_bit_en),
    .space     (~rx_mark),
    .run_len   (rx_run),
    .run_after (rx_run_after)
  );

  lam_density_window #(.WIN_LEN(WIN_LEN), .PW(PW)) u_rx_win (
    .clk       (clk),
    .rst       (rst),
    .step      (rx_bit_en),
    .mark      (rx_mark),
    .pop_after (rx_pop_after)
  );

  logic los_set, los_rel, los_d;
  assign los_set = rx_bit_en && !los_alarm && (rx_run_after >= LOS_RUN_V);
  assign los_rel = rx_bit_en && los_alarm && (rx_pop_after >= MIN_MARK_V)
                   && (rx_run_after <= MAX_GAP_V);
  assign los_d   = los_set | (los_alarm & ~los_rel);

  always_ff @(posedge clk) begin
    if (rst) begin
      los_alarm      <= 1'b0;
      los_change     <= 1'b0;
      clk_sel_master <= 1'b0;
    end else begin
      los_alarm      <= los_d;
      los_change     <= los_d ^ los_alarm;
      clk_sel_master <= los_d;
    end
  end

  // ---------------- transmit monitor side ----------------
  logic [TW-1:0] tx_run, tx_run_after;

  lam_run_counter #(.LIMIT(DRV_RUN), .W(TW)) u_tx_run (
    .clk       (clk),
    .rst       (rst),
    .clr       (drv_clr),
    .step      (tx_bit_en),
    .space     (~tx_mark),
    .run_len   (tx_run),
    .run_after (tx_run_after)
  );

  logic drv_set, drv_hit, drv_d;
  assign drv_set = tx_bit_en && !drv_alarm && (tx_run_after >= DRV_RUN_V);
  assign drv_hit = tx_bit_en && tx_mark;
  assign drv_d   = drv_clr ? 1'b0 : (drv_set | (drv_alarm & ~drv_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_alarm  <= 1'b0;
      drv_change <= 1'b0;
    end else begin
      drv_alarm  <= drv_d;
      drv_change <= drv_d ^ drv_alarm;
    end
  end

endmodule

// File: rtl/line_alarm_monitor_chk.sv
module lam_checker (
  input logic clk,
  input logic rst,
  input logic rx_bit_en,
  input logic rx_pos,
  input logic rx_neg,
  input logic tx_bit_en,
  input logic tx_pos,
  input logic tx_neg,
  input logic drv_clr,
  input logic los_alarm,
  input logic los_change,
  input logic clk_sel_master,
  input logic drv_alarm,
  input logic drv_change
);

  // R2
  los_rise_on_space_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los_alarm) |-> $past(rx_bit_en && !rx_pos && !rx_neg));

  // R3
  los_fall_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los_alarm) |-> $past(rx_bit_en));

  // R4
  clk_sel_follows_chk: assert property (@(posedge clk) disable iff (rst)
    clk_sel_master == los_alarm);

  // R5
  los_change_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    los_change == (los_alarm != $past(los_alarm)));

  // R7
  drv_mark_release_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_bit_en && (tx_pos || tx_neg)) |=> !drv_alarm);

  // R8
  drv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    drv_clr |=> !drv_alarm);

  // R9
  drv_change_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    drv_change == (drv_alarm != $past(drv_alarm)));

  // R10
  los_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_bit_en |=> $stable(los_alarm));

endmodule

bind line_alarm_monitor lam_checker u_chk (.*);

// File: tb/line_alarm_monitor_tb.sv
`timescale 1ns/1ps
module line_alarm_monitor_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit_en = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic tx_bit_en = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
  logic drv_clr = 1'b0;
  logic los_alarm, los_change, clk_sel_master, drv_alarm, drv_change;

  always #10 clk = ~clk;

  line_alarm_monitor u_dut (
    .clk(clk), .rst(rst),
    .rx_bit_en(rx_bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .tx_bit_en(tx_bit_en), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .drv_clr(drv_clr),
    .los_alarm(los_alarm), .los_change(los_change),
    .clk_sel_master(clk_sel_master),
    .drv_alarm(drv_alarm), .drv_change(drv_change)
  );

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic  alarm;
    logic  change;
    string tag;
  } exp_t;

  exp_t rx_q[$];
  exp_t tx_q[$];

  // reference state built from the requirements
  int   m_rx_zeros = 0;
  logic [31:0] m_win = '0;
  logic m_los = 1'b0;
  int   m_tx_zeros = 0;
  logic m_drv = 1'b0;
  logic pol = 1'b0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rx_zeros = 0; m_win = '0; m_los = 1'b0;
    m_tx_zeros = 0; m_drv = 1'b0;
  endtask

  // Driver: one receive bit, expected result pushed to the scoreboard.
  task automatic rx_bit(input logic m, input string tag);
    exp_t e;
    logic prev;
    @(negedge clk);
    tx_bit_en = 1'b0;
    rx_bit_en = 1'b1;
    pol = ~pol;
    rx_pos = m & pol;
    rx_neg = m & ~pol;
    prev = m_los;
    m_rx_zeros = m ? 0 : ((m_rx_zeros >= 175) ? 175 : m_rx_zeros + 1);
    m_win = {m_win[30:0], m};
    if (!m_los && m_rx_zeros >= 175) m_los = 1'b1;
    else if (m_los && $countones(m_win) >= 4 && m_rx_zeros <= 15) m_los = 1'b0;
    e.alarm = m_los; e.change = m_los ^ prev; e.tag = tag;
    rx_q.push_back(e);
  endtask

  task automatic rx_run(input int n, input string tag);
    for (int i = 0; i < n; i++) rx_bit(1'b0, tag);
  endtask

  task automatic tx_bit(input logic m, input logic neg_rail, input string tag);
    exp_t e;
    logic prev;
    @(negedge clk);
    rx_bit_en = 1'b0;
    tx_bit_en = 1'b1;
    tx_pos = m & ~neg_rail;
    tx_neg = m & neg_rail;
    prev = m_drv;
    m_tx_zeros = m ? 0 : ((m_tx_zeros >= 63) ? 63 : m_tx_zeros + 1);
    if (!m_drv && m_tx_zeros >= 63) m_drv = 1'b1;
    else if (m_drv && m) m_drv = 1'b0;
    e.alarm = m_drv; e.change = m_drv ^ prev; e.tag = tag;
    tx_q.push_back(e);
  endtask

  task automatic tx_run(input int n, input string tag);
    for (int i = 0; i < n; i++) tx_bit(1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_bit_en = 1'b0; tx_bit_en = 1'b0;
      rx_pos = 1'b0; rx_neg = 1'b0; tx_pos = 1'b0; tx_neg = 1'b0;
    end
  endtask

  task automatic do_reset();
    idle(1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1", "los_alarm", los_alarm, 1'b0);
    chk("R1", "los_change", los_change, 1'b0);
    chk("R1", "clk_sel_master", clk_sel_master, 1'b0);
    chk("R1", "drv_alarm", drv_alarm, 1'b0);
    chk("R1", "drv_change", drv_change, 1'b0);
  endtask

  // Monitor: compare after every edge that consumed a strobe.
  always @(posedge clk) begin
    logic rs, ts;
    exp_t e;
    rs = rx_bit_en & ~rst;
    ts = tx_bit_en & ~rst;
    #5;
    if (rs && rx_q.size() > 0) begin
      e = rx_q.pop_front();
      chk(e.tag, "los_alarm", los_alarm, e.alarm);
      chk(e.tag, "los_change (R5)", los_change, e.change);
      chk("R4", "clk_sel_master", clk_sel_master, e.alarm);
    end
    if (ts && tx_q.size() > 0) begin
      e = tx_q.pop_front();
      chk(e.tag, "drv_alarm", drv_alarm, e.alarm);
      chk(e.tag, "drv_change (R9)", drv_change, e.change);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    do_reset();

    // R2: 174 spaces are not enough, a mark restarts the count, the 175th raises
    rx_run(174, "R2");
    rx_bit(1'b1, "R2");
    rx_run(174, "R2");
    rx_run(1, "R2");
    rx_run(30, "R2");

    // R3: marks 11 apart never fit 4 in a window, alarm stays high
    for (int k = 0; k < 10; k++) begin
      rx_bit(1'b1, "R3");
      rx_run(10, "R3");
    end
    // R3: marks 8 apart release on the 4th one inside a window
    for (int k = 0; k < 6; k++) begin
      rx_bit(1'b1, "R3");
      rx_run(7, "R3");
    end

    // R10: rails toggling without a strobe leave the count untouched
    rx_run(100, "R10");
    @(negedge clk);
    rx_bit_en = 1'b0; rx_pos = 1'b1; rx_neg = 1'b0;
    @(negedge clk);
    rx_pos = 1'b0; rx_neg = 1'b1;
    @(negedge clk);
    rx_neg = 1'b0;
    chk("R10", "los_alarm after unstrobed rails", los_alarm, 1'b0);
    rx_run(74, "R10");
    rx_run(1, "R10");
    // R11: four marks on alternating rails release the alarm
    for (int k = 0; k < 4; k++) begin
      rx_bit(1'b1, "R11");
      rx_run(2, "R11");
    end
    idle(2);

    // R1: reset mid-run restarts the space count
    rx_run(170, "R1");
    do_reset();
    rx_run(170, "R1");
    rx_run(5, "R1");
    for (int k = 0; k < 4; k++) rx_bit(1'b1, "R3");
    idle(2);

    // R6: 62 spaces do not raise, the 63rd does
    tx_run(62, "R6");
    tx_run(1, "R6");
    tx_run(20, "R6");
    // R7 / R11: one negative-rail mark releases
    tx_bit(1'b1, 1'b1, "R7");
    tx_run(62, "R7");
    tx_bit(1'b1, 1'b0, "R11");
    tx_run(63, "R6");

    // R8: clear pulse drops alarm and the run count
    idle(1);
    @(negedge clk);
    drv_clr = 1'b1;
    @(negedge clk);
    drv_clr = 1'b0;
    chk("R8", "drv_alarm after clear", drv_alarm, 1'b0);
    chk("R9", "drv_change after clear", drv_change, 1'b1);
    m_drv = 1'b0; m_tx_zeros = 0;
    tx_run(62, "R8");
    tx_run(1, "R8");

    // R8: clear beats a same-cycle space strobe
    tx_run(5, "R8");
    @(negedge clk);
    tx_bit_en = 1'b1; tx_pos = 1'b0; tx_neg = 1'b0; drv_clr = 1'b1;
    @(negedge clk);
    tx_bit_en = 1'b0; drv_clr = 1'b0;
    chk("R8", "drv_alarm clear priority", drv_alarm, 1'b0);
    m_drv = 1'b0; m_tx_zeros = 0;
    tx_run(63, "R8");
    idle(4);

    chk("R5", "receive queue drained", rx_q.size() == 0, 1'b1);
    chk("R9", "transmit queue drained", tx_q.size() == 0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule